// File: doc/BRIEF.md
# Non-Stoppable Keyed Watchdog Timer

This block is a watchdog that counts cycles of a dedicated low-speed oscillator clock. It starts counting as soon as reset is released, with the longest period selected. No register setting and no low-power indication can stop it. Software keeps it from expiring in one of two ways. It can write a fixed key byte to the clear register, or it can write anything to the mode register. Either write restarts the count from zero. If the count reaches the end of the selected period, the block issues a reset request for the rest of the chip. Writing any other byte to the clear register is treated as a runaway program and raises the request at once.

Register writes arrive in the bus clock domain. Every write is accepted in the cycle it is presented, so there is no back-pressure. A restart is carried into the oscillator domain by a toggle handshake. The period code travels with it and is held stable until the oscillator side acknowledges. Restarts that arrive while a handshake is in flight are merged into one pending restart, which uses the newest period code. Expiry events come back to the bus domain as a toggle. There they become a reset-request pulse one bus cycle wide. Period code `c` selects an expiry after 2^(BASE_LOG2+c) oscillator cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: While reset is applied and just after it, the mode readback is 8'h1F and `rst_req` is low. In the mode register, bits [2:0] are the period code, bits [4:3] are a fixed clock-source field that reads 2'b11, and bits [7:5] read zero.
- R2: With no writes after reset release, the first `rst_req` pulse comes 2^(BASE_LOG2+7) oscillator cycles after release, give or take the crossing latency of at most 10 oscillator cycles.
- R3: After a mode write with period code c (0..7), the next `rst_req` comes 2^(BASE_LOG2+c) oscillator cycles after the write, within the same latency bound.
- R4: Writing 8'hAC to the clear register (`wr_sel`=1) restarts the count from zero. Writing it more often than once per period prevents any `rst_req`.
- R5: Any write to the mode register (`wr_sel`=0) restarts the count, even when it rewrites the same period code.
- R6: A mode write stores only data bits [2:0]. Data bits [4:3] are ignored and keep reading 2'b11, and bits [7:5] keep reading zero.
- R7: `stop_req` has no effect: the count advances and expires the same way whatever its level.
- R8: A write to the clear register with any value other than 8'hAC raises `rst_req` in the bus cycle after the write.
- R9: `rst_req` never stays high for two bus cycles in a row. Request causes that land in adjacent cycles merge into one pulse.
- R10: After an expiry the count wraps to zero and keeps running. Without a restart, the next `rst_req` follows one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assertion |
| osc_clk | input | 1 | Free-running low-speed oscillator clock that drives the count |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_sel | input | 1 | Register select: 0 = mode, 1 = clear/key |
| wr_data | input | 8 | Write data |
| stop_req | input | 1 | Low-power/stop indication, deliberately ignored |
| mode_rdata | output | 8 | Mode register readback |
| rst_req | output | 1 | Single-cycle reset request in the bus domain |

## Verification
The bench shrinks the base period and sweeps every period code, with a fresh reset before each one. It measures in oscillator cycles how long each expiry takes, so a decode that is off by one code shows up as a period that is twice or half as long. It keeps restarting the count with keyed writes and, separately, with repeated writes of the same mode value. A design that drops a restart in the handshake, or fails to clear on a mode rewrite, would then raise a request that should not appear. It also writes near-miss key values, which must produce an immediate one-cycle request. It holds the stop indication high during a measured period and checks that a design which gated the count on it would expire late.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] CLEAR_KEY  = 8'hAC;
  localparam logic [1:0] CLKSRC_RST = 2'b11;
  localparam int         REG_W      = 8;

  typedef enum logic {
    REG_MODE = 1'b0,
    REG_KEY  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/wdt_sync2.sv
module wdt_sync2 #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mode_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             clr_evt,
  output logic             bad_key
);
  localparam int PAD_W = REG_W - SEL_W - 2;

  logic mode_wr, key_wr, key_ok;

  assign mode_wr = wr_en && (wr_sel == REG_MODE);
  assign key_wr  = wr_en && (wr_sel == REG_KEY);
  assign key_ok  = (wr_data == CLEAR_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '1;
    else if (mode_wr) sel_q <= wr_data[SEL_W-1:0];
  end

  assign mode_q  = {{PAD_W{1'b0}}, CLKSRC_RST, sel_q};
  assign clr_evt = mode_wr || (key_wr && key_ok);
  assign bad_key = key_wr && !key_ok;

  p_mode_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_q[SEL_W-1:0] == $past(wr_data[SEL_W-1:0])) &&
                (mode_q[SEL_W+1:SEL_W] == CLKSRC_RST));
endmodule

// File: rtl/wdt_launch.sv
module wdt_launch #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_evt,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             ack_sync,
  output logic             req_tgl,
  output logic [SEL_W-1:0] sel_launch
);
  logic pend;
  logic busy;

  assign busy = (req_tgl != ack_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      req_tgl    <= 1'b0;
      sel_launch <= '1;
    end else if (!busy && pend) begin
      req_tgl    <= ~req_tgl;
      sel_launch <= sel_in;
      pend       <= clr_evt;
    end else if (clr_evt) begin
      pend <= 1'b1;
    end
  end

  p_hold_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(req_tgl) && $stable(sel_launch));
  p_keep_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> pend);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_LOG2 = 11,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_sync,
  input  logic [SEL_W-1:0] sel_bus,
  input  logic             stop_hint,
  output logic             ack_tgl,
  output logic             ovf_tgl
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic             req_d;
  logic             clr;
  logic [SEL_W-1:0] sel_act;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             hit;

  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_lim
    assign lim[gi] = (gi < (BASE_LOG2 + int'(sel_act)));
  end

  assign clr     = req_sync ^ req_d;
  assign hit     = (cnt == lim);
  assign ack_tgl = req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d   <= 1'b0;
      sel_act <= '1;
      cnt     <= '0;
      ovf_tgl <= 1'b0;
    end else begin
      req_d <= req_sync;
      if (clr) begin
        cnt     <= '0;
        sel_act <= sel_bus;
      end else if (hit) begin
        cnt     <= '0;
        ovf_tgl <= ~ovf_tgl;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (cnt == '0) && (ovf_tgl != $past(ovf_tgl)));
  p_runs_in_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hint && !clr && !hit) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int SEL_W     = 3
) (
  input  logic       bus_clk,
  input  logic       rst_n,
  input  logic       osc_clk,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       stop_req,
  output logic [7:0] mode_rdata,
  output logic       rst_req
);
  logic [SEL_W-1:0] sel_q, sel_launch;
  logic             clr_evt, bad_key;
  logic             req_tgl, req_s, ack_tgl, ack_s;
  logic             ovf_tgl, ovf_s, ovf_d, ovf_evt;
  logic             osc_rst_n, stop_s;

  wdt_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mode_q(mode_rdata), .sel_q(sel_q),
    .clr_evt(clr_evt), .bad_key(bad_key)
  );

  wdt_launch #(.SEL_W(SEL_W)) u_launch (
    .clk(bus_clk), .rst_n(rst_n), .clr_evt(clr_evt), .sel_in(sel_q),
    .ack_sync(ack_s), .req_tgl(req_tgl), .sel_launch(sel_launch)
  );

  wdt_sync2 #(.W(1)) u_osc_rst (
    .clk(osc_clk), .rst_n(rst_n), .d(1'b1), .q(osc_rst_n)
  );
  wdt_sync2 #(.W(2)) u_to_osc (
    .clk(osc_clk), .rst_n(osc_rst_n), .d({req_tgl, stop_req}), .q({req_s, stop_s})
  );

  wdt_counter #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_cnt (
    .clk(osc_clk), .rst_n(osc_rst_n), .req_sync(req_s), .sel_bus(sel_launch),
    .stop_hint(stop_s), .ack_tgl(ack_tgl), .ovf_tgl(ovf_tgl)
  );

  wdt_sync2 #(.W(2)) u_to_bus (
    .clk(bus_clk), .rst_n(rst_n), .d({ack_tgl, ovf_tgl}), .q({ack_s, ovf_s})
  );

  assign ovf_evt = ovf_s ^ ovf_d;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_d   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      ovf_d   <= ovf_s;
      rst_req <= (ovf_evt || bad_key) && !rst_req;
    end
  end

  p_bad_key_r8: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bad_key && !rst_req) |=> rst_req);
  p_pulse_r9: assert property (@(posedge bus_clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_expiry_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (ovf_evt && !rst_req) |=> rst_req);
endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_PERIOD = 3 * CLK_PERIOD;
  localparam int BASE       = 3;
  localparam int LAT        = 10;
  localparam int WD_LIMIT   = 150000;

  logic       bus_clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, stop_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] mode_rdata;
  logic       rst_req;

  int nchk = 0, nerr = 0, osc_ticks = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #(OSC_PERIOD/2) osc_clk = ~osc_clk;
  always @(posedge osc_clk) osc_ticks++;

  keyed_watchdog #(.BASE_LOG2(BASE), .SEL_W(3)) u0 (
    .bus_clk(bus_clk), .rst_n(rst_n), .osc_clk(osc_clk), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .stop_req(stop_req),
    .mode_rdata(mode_rdata), .rst_req(rst_req)
  );

  always @(posedge bus_clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(output int t0);
    @(negedge bus_clk); rst_n = 1'b0;
    repeat (4) @(negedge bus_clk);
    rst_n = 1'b1;
    t0 = osc_ticks;
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    @(negedge bus_clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge bus_clk); wr_en = 1'b0;
  endtask

  // waits for a request pulse, then checks it is one cycle wide (R9)
  task automatic wait_rst(input int limit, output int t, output bit got);
    got = 0; t = 0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge bus_clk);
      if (rst_req) begin
        t = osc_ticks; got = 1;
        @(negedge bus_clk);
        chk(!rst_req, "R9 pulse width", int'(rst_req), 0);
      end
    end
  endtask

  task automatic measure(input string req, input int t0, input int per);
    int t; bit got;
    wait_rst(per * 3 + 200, t, got);
    chk(got && (t - t0) >= per && (t - t0) <= per + LAT, req, got ? t - t0 : -1, per);
  endtask

  initial begin
    int t0, t1, t2, per;
    bit got;

    // R1: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge bus_clk);
    chk(mode_rdata == 8'h1F, "R1 mode during reset", mode_rdata, 8'h1F);
    chk(rst_req == 1'b0, "R1 rst_req during reset", rst_req, 0);
    do_reset(t0);
    chk(mode_rdata == 8'h1F, "R1 mode after release", mode_rdata, 8'h1F);
    // R2: default longest period
    measure("R2 default period", t0, 1 << (BASE + 7));

    // R3 / R6: sweep every period code
    for (int c = 0; c < 8; c++) begin
      do_reset(t0);
      bus_wr(1'b0, {3'b111, 2'b00, 3'(c)});
      t1 = osc_ticks;
      chk(mode_rdata == {3'b000, 2'b11, 3'(c)}, "R6 mode readback", mode_rdata,
          {3'b000, 2'b11, 3'(c)});
      measure("R3 period code", t1, 1 << (BASE + c));
    end

    // R10: wrap and repeat
    do_reset(t0);
    bus_wr(1'b0, 8'h01);
    per = 1 << (BASE + 1);
    wait_rst(per * 3 + 200, t1, got);
    wait_rst(per * 3 + 200, t2, got);
    chk(got && (t2 - t1) >= per - 1 && (t2 - t1) <= per + 1, "R10 repeat period",
        t2 - t1, per);

    // R4: keyed restarts hold off expiry
    do_reset(t0);
    bus_wr(1'b0, 8'h02);
    per = 1 << (BASE + 2);
    got = 0;
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge bus_clk);
        if (rst_req) got = 1;
      end
      bus_wr(1'b1, 8'hAC);
      if (rst_req) got = 1;
    end
    t1 = osc_ticks;
    chk(!got, "R4 key restart prevents request", int'(got), 0);
    chk(mode_rdata == 8'h1A, "R4 key leaves mode", mode_rdata, 8'h1A);
    measure("R4 expiry after last key", t1, per);

    // R5: rewriting the same mode value restarts
    do_reset(t0);
    got = 0;
    for (int k = 0; k < 12; k++) begin
      bus_wr(1'b0, 8'h02);
      if (rst_req) got = 1;
      for (int i = 0; i < 40; i++) begin
        @(negedge bus_clk);
        if (rst_req) got = 1;
      end
    end
    chk(!got, "R5 mode write restarts", int'(got), 0);

    // R7: stop indication does not stop counting
    do_reset(t0);
    stop_req = 1'b1;
    bus_wr(1'b0, 8'h03);
    t1 = osc_ticks;
    measure("R7 counts under stop", t1, 1 << (BASE + 3));
    stop_req = 1'b0;

    // R8: wrong key values
    do_reset(t0);
    bus_wr(1'b1, 8'h55);
    chk(rst_req == 1'b1, "R8 bad key 55", rst_req, 1);
    @(negedge bus_clk);
    chk(rst_req == 1'b0, "R9 bad key pulse ends", rst_req, 0);
    bus_wr(1'b1, 8'hAD);
    chk(rst_req == 1'b1, "R8 bad key AD", rst_req, 1);
    bus_wr(1'b1, 8'hAC);
    chk(rst_req == 1'b0, "R8 good key no request", rst_req, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule